// File: doc/BRIEF.md
# Auto-Incrementing Register Target for a Two-Wire Serial Bus

This block is the target side of an I2C link into a 16-byte register file. It oversamples SCL and SDA on the system clock and finds START and STOP conditions. It compares the first byte of every transfer against its 7-bit device address and then moves data one byte at a time. The first data byte of a write sets an internal 4-bit pointer. Every later written byte goes out on a one-cycle write strobe, at the pointer's address. A read returns the byte at the pointer. That read can follow a repeated START, or it can begin at once from whatever pointer value is left from the previous transfer. The register storage is outside the block. The block gives the current pointer and takes back the byte stored there.

The block drives SDA only through an open-drain enable. When the enable is high, the line is pulled low. It also has a hold output. A timekeeping block uses hold to stop updating its clock registers while a transfer is working in the clock range, addresses 0 to 7. Hold clears on STOP or as soon as the pointer moves to 8 or above.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, the open-drain enable is low, hold is low and the pointer is 0.
- R2: The block acknowledges the address byte 8'hD0 (write) and 8'hD1 (read) by pulling SDA low while SCL is high in the ninth clock. It starts driving SDA only while SCL is low, and it never drives SDA while the controller is sending a bit.
- R3: If the upper seven bits of the address byte are not 7'b1101000, the block gives no acknowledge. It keeps SDA released until the next START or STOP, and it writes no register and leaves the pointer unchanged.
- R4: In a write, the low 4 bits of the first data byte load the pointer. Each later byte is acknowledged and written to the pointer's address, so consecutive bytes land at consecutive addresses.
- R5: The pointer increases by one on the ninth (acknowledge) clock of every data byte, read or written, whether that bit is ACK or NACK. The pointer-setting byte does not increment it. The pointer wraps from 15 to 0.
- R6: After a repeated START with address 8'hD1, the block sends the byte at the pointer MSB first. It sends the following bytes for as long as the controller acknowledges.
- R7: A read transfer that begins without a pointer write starts at the stored pointer value.
- R8: Hold is high while the block is addressed and the pointer is in 0..7. It falls once the pointer reaches 8..15, in both read and write.
- R9: After the controller NACKs a read byte, SDA stays released until the next START or STOP, and the pointer stops advancing.
- R10: A START that arrives in the middle of a byte discards the partial byte and restarts address reception.
- R11: A STOP clears hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both bus lines are oversampled on it |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls SDA low |
| reg_ptr_o | output | 4 | Current register pointer |
| rd_data_i | input | 8 | Register byte at reg_ptr_o |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 4 | Register write address |
| wr_data_o | output | 8 | Register write data |
| hold_o | output | 1 | Freeze request for the clock registers |

## Verification
A wrong bit counter or a wrong state shows up within one byte time. It appears as a missing or misplaced acknowledge, or as SDA being pulled during a bit the controller owns. An off-by-one in the pointer appears at reg_ptr_o after the ninth clock. It also shows up as read bytes coming from the wrong address, or as writes landing in the wrong register, which the final register compare catches. A stuck selection flag shows up within a few cycles of STOP as hold staying high. It can also show up as hold not rising during an access to the clock range.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BIT,
    ST_WR_ACK,
    ST_RD_BIT,
    ST_RD_ACK,
    ST_IGNORE
  } eng_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= 1'b1;
          sda_pipe <= 1'b1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
  parameter int unsigned PTR_W      = 4,
  parameter int unsigned HOLD_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ptr_load,
  input  logic [PTR_W-1:0] ptr_val,
  input  logic             ptr_inc,
  input  logic             sel_set,
  input  logic             sel_clr,
  output logic [PTR_W-1:0] ptr_q,
  output logic             hold_q
);
  localparam logic [PTR_W:0] LIM = (PTR_W+1)'(HOLD_LIMIT);

  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (ptr_load) begin
      ptr_q <= ptr_val;
    end else if (ptr_inc) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
    end else if (sel_clr) begin
      sel_q <= 1'b0;
    end else if (sel_set) begin
      sel_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
    end else begin
      hold_q <= sel_q && ({1'b0, ptr_q} < LIM);
    end
  end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h68,
  parameter int unsigned PTR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 sda_s,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic [BYTE_BITS-1:0] rd_data,
  input  logic [PTR_W-1:0]     ptr_i,
  output logic                 sda_oe,
  output logic                 wr_en,
  output logic [PTR_W-1:0]     wr_addr,
  output logic [BYTE_BITS-1:0] wr_data,
  output logic                 ptr_load,
  output logic [PTR_W-1:0]     ptr_val,
  output logic                 ptr_inc,
  output logic                 sel_set,
  output logic                 sel_clr
);
  localparam int unsigned      CNT_W    = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

  eng_state_t             state;
  logic [CNT_W-1:0]       bitcnt;
  logic [BYTE_BITS-1:0]   shreg;
  logic                   ack_ph;
  logic                   rw;
  logic                   first_wr;
  logic                   mack;
  logic [BYTE_BITS-1:0]   byte_in;

  assign byte_in = {shreg[BYTE_BITS-2:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      ack_ph   <= 1'b0;
      rw       <= 1'b0;
      first_wr <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      ptr_load <= 1'b0;
      ptr_val  <= '0;
      ptr_inc  <= 1'b0;
      sel_set  <= 1'b0;
      sel_clr  <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      ptr_load <= 1'b0;
      ptr_inc  <= 1'b0;
      sel_set  <= 1'b0;
      sel_clr  <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        sda_oe  <= 1'b0;
        sel_clr <= 1'b1;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg  <= byte_in;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_BIT) begin
                if (byte_in[BYTE_BITS-1:1] == DEV_ADDR) begin
                  state   <= ST_ADDR_ACK;
                  rw      <= byte_in[0];
                  ack_ph  <= 1'b0;
                  sel_set <= 1'b1;
                end else begin
                  state   <= ST_IGNORE;
                  sel_clr <= 1'b1;
                end
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_rise) begin
              ack_ph <= 1'b1;
            end else if (scl_fall) begin
              if (!ack_ph) begin
                sda_oe <= 1'b1;
              end else begin
                ack_ph <= 1'b0;
                bitcnt <= '0;
                if (rw) begin
                  state  <= ST_RD_BIT;
                  shreg  <= rd_data;
                  sda_oe <= ~rd_data[BYTE_BITS-1];
                end else begin
                  state    <= ST_WR_BIT;
                  first_wr <= 1'b1;
                  sda_oe   <= 1'b0;
                end
              end
            end
          end
          ST_WR_BIT: begin
            if (scl_rise) begin
              shreg  <= byte_in;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_BIT) begin
                state  <= ST_WR_ACK;
                ack_ph <= 1'b0;
                if (first_wr) begin
                  ptr_load <= 1'b1;
                  ptr_val  <= byte_in[PTR_W-1:0];
                end else begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr_i;
                  wr_data <= byte_in;
                end
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_rise) begin
              ack_ph  <= 1'b1;
              ptr_inc <= ~first_wr;
            end else if (scl_fall) begin
              if (!ack_ph) begin
                sda_oe <= 1'b1;
              end else begin
                ack_ph   <= 1'b0;
                sda_oe   <= 1'b0;
                first_wr <= 1'b0;
                bitcnt   <= '0;
                state    <= ST_WR_BIT;
              end
            end
          end
          ST_RD_BIT: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_BIT) begin
                state  <= ST_RD_ACK;
                ack_ph <= 1'b0;
              end
            end else if (scl_fall) begin
              shreg  <= {shreg[BYTE_BITS-2:0], 1'b0};
              sda_oe <= ~shreg[BYTE_BITS-2];
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              ack_ph  <= 1'b1;
              ptr_inc <= 1'b1;
              mack    <= ~sda_s;
            end else if (scl_fall) begin
              if (!ack_ph) begin
                sda_oe <= 1'b0;
              end else begin
                ack_ph <= 1'b0;
                bitcnt <= '0;
                if (mack) begin
                  state  <= ST_RD_BIT;
                  shreg  <= rd_data;
                  sda_oe <= ~rd_data[BYTE_BITS-1];
                end else begin
                  state  <= ST_IGNORE;
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [6:0]  DEV_ADDR    = 7'h68,
  parameter int unsigned PTR_W       = 4,
  parameter int unsigned HOLD_LIMIT  = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic [PTR_W-1:0] reg_ptr_o,
  input  logic [7:0]       rd_data_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o,
  output logic             hold_o
);
  logic             scl_s;
  logic             sda_s;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_det;
  logic             stop_det;
  logic             ptr_load;
  logic [PTR_W-1:0] ptr_val;
  logic             ptr_inc;
  logic             sel_set;
  logic             sel_clr;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data_i),
    .ptr_i     (reg_ptr_o),
    .sda_oe    (sda_oe_o),
    .wr_en     (wr_en_o),
    .wr_addr   (wr_addr_o),
    .wr_data   (wr_data_o),
    .ptr_load  (ptr_load),
    .ptr_val   (ptr_val),
    .ptr_inc   (ptr_inc),
    .sel_set   (sel_set),
    .sel_clr   (sel_clr)
  );

  i2c_tgt_ptr #(.PTR_W(PTR_W), .HOLD_LIMIT(HOLD_LIMIT)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .ptr_load (ptr_load),
    .ptr_val  (ptr_val),
    .ptr_inc  (ptr_inc),
    .sel_set  (sel_set),
    .sel_clr  (sel_clr),
    .ptr_q    (reg_ptr_o),
    .hold_q   (hold_o)
  );
endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk #(
  parameter int unsigned PTR_W      = 4,
  parameter int unsigned HOLD_LIMIT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_oe_o,
  input logic             hold_o,
  input logic [PTR_W-1:0] reg_ptr_o,
  input logic             wr_en_o,
  input logic             scl_s,
  input logic             stop_det,
  input logic             ptr_load
);
  localparam logic [PTR_W:0] LIM = (PTR_W+1)'(HOLD_LIMIT);

  // R2: the line is only newly pulled while SCL is low
  a_r2_drive_on_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_s);

  // R5: apart from a load, the pointer only ever steps by one
  a_r5_step_by_one: assert property (@(posedge clk) disable iff (rst)
    ((reg_ptr_o != $past(reg_ptr_o)) && !$past(ptr_load))
      |-> (reg_ptr_o == PTR_W'($past(reg_ptr_o) + 1'b1)));

  // R8: hold only follows a pointer inside the clock range
  a_r8_hold_in_range: assert property (@(posedge clk) disable iff (rst)
    hold_o |-> ({1'b0, $past(reg_ptr_o)} < LIM));

  // R11: STOP clears hold after the pulse and flag registers
  a_r11_stop_clears_hold: assert property (@(posedge clk) disable iff (rst)
    stop_det |-> ##3 !hold_o);

  // R4: each written byte is a single strobe
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> !wr_en_o);
endmodule

bind i2c_regfile_target i2c_regfile_target_chk #(
  .PTR_W(PTR_W), .HOLD_LIMIT(HOLD_LIMIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sda_oe_o  (sda_oe_o),
  .hold_o    (hold_o),
  .reg_ptr_o (reg_ptr_o),
  .wr_en_o   (wr_en_o),
  .scl_s     (scl_s),
  .stop_det  (stop_det),
  .ptr_load  (ptr_load)
);

// File: tb/i2c_regfile_target_test.sv
`timescale 1ns/1ps
module i2c_regfile_target_test;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       m_owns = 1'b0;
  logic       sda_oe_o;
  logic [3:0] reg_ptr_o;
  logic [7:0] rd_data_i;
  logic       wr_en_o;
  logic [3:0] wr_addr_o;
  logic [7:0] wr_data_o;
  logic       hold_o;
  logic       line;
  logic [7:0] regs [16];
  logic [7:0] exp_mem [16];
  int         n_checks = 0;
  int         n_err = 0;
  int         contention = 0;
  int         exp_ptr = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  assign line      = sda_m & ~sda_oe_o;
  assign rd_data_i = regs[reg_ptr_o];

  i2c_regfile_target uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(line), .sda_oe_o(sda_oe_o),
    .reg_ptr_o(reg_ptr_o), .rd_data_i(rd_data_i), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .hold_o(hold_o)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37 + 11);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) regs[i] <= init_val(i);
    end else if (wr_en_o) begin
      regs[wr_addr_o] <= wr_data_o;
    end
  end

  always @(negedge clk) if (m_owns && sda_oe_o) contention++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b1; waitc(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; waitc(Q);
    scl_m = 1'b1; m_owns = 1'b1; waitc(2 * Q);
    m_owns = 1'b0; scl_m = 1'b0; waitc(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    acked = (line == 1'b0);
    waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitc(Q);
      scl_m = 1'b1; waitc(Q);
      b[i] = line;
      waitc(Q);
      scl_m = 1'b0; waitc(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; waitc(Q);
    scl_m = 1'b1; m_owns = 1'b1; waitc(2 * Q);
    m_owns = 1'b0; scl_m = 1'b0; waitc(Q);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    bit         ack;
    logic [7:0] d;
    for (int i = 0; i < 16; i++) exp_mem[i] = init_val(i);
    waitc(10);
    rst = 1'b0;
    waitc(5);
    check(sda_oe_o == 1'b0, "R1 oe after reset", int'(sda_oe_o), 0);
    check(hold_o == 1'b0, "R1 hold after reset", int'(hold_o), 0);
    check(reg_ptr_o == 4'd0, "R1 pointer after reset", int'(reg_ptr_o), 0);

    // write burst at 5
    bus_start();
    wr_byte(8'hD0, ack); check(ack, "R2 write address ack", int'(ack), 1);
    wr_byte(8'h05, ack); check(ack, "R4 pointer byte ack", int'(ack), 1);
    exp_ptr = 5;
    waitc(4);
    check(reg_ptr_o == 4'(exp_ptr), "R4 pointer loaded", int'(reg_ptr_o), exp_ptr);
    check(hold_o == 1'b1, "R8 hold in clock range (write)", int'(hold_o), 1);
    for (int k = 0; k < 3; k++) begin
      wr_byte(8'(8'h11 * (k + 1)), ack);
      check(ack, "R4 data byte ack", int'(ack), 1);
      exp_mem[exp_ptr] = 8'(8'h11 * (k + 1));
      exp_ptr = (exp_ptr + 1) % 16;
    end
    waitc(4);
    check(reg_ptr_o == 4'(exp_ptr), "R5 pointer after write burst", int'(reg_ptr_o), exp_ptr);
    check(hold_o == 1'b0, "R8 hold released at 8", int'(hold_o), 0);
    bus_stop();

    // pointer set, repeated START, read across wrap
    bus_start();
    wr_byte(8'hD0, ack); check(ack, "R2 address ack", int'(ack), 1);
    wr_byte(8'h0E, ack); check(ack, "R4 pointer byte ack", int'(ack), 1);
    exp_ptr = 14;
    bus_start();
    wr_byte(8'hD1, ack); check(ack, "R2 read address ack", int'(ack), 1);
    for (int k = 0; k < 3; k++) begin
      rd_byte(k < 2, d);
      check(d == exp_mem[exp_ptr], "R6 read byte after repeated start", int'(d), int'(exp_mem[exp_ptr]));
      exp_ptr = (exp_ptr + 1) % 16;
    end
    bus_stop();
    waitc(4);
    check(reg_ptr_o == 4'(exp_ptr), "R5 pointer wrapped", int'(reg_ptr_o), exp_ptr);

    // current-address read, NACK, then released line
    bus_start();
    wr_byte(8'hD1, ack); check(ack, "R2 read address ack", int'(ack), 1);
    waitc(2);
    check(hold_o == 1'b1, "R8 hold in clock range (read)", int'(hold_o), 1);
    rd_byte(1'b0, d);
    check(d == exp_mem[exp_ptr], "R7 read from stored pointer", int'(d), int'(exp_mem[exp_ptr]));
    exp_ptr = (exp_ptr + 1) % 16;
    check(sda_oe_o == 1'b0, "R9 line released after nack", int'(sda_oe_o), 0);
    rd_byte(1'b1, d);
    check(d == 8'hFF, "R9 no drive after nack", int'(d), 8'hFF);
    check(reg_ptr_o == 4'(exp_ptr), "R9 pointer frozen after nack", int'(reg_ptr_o), exp_ptr);
    bus_stop();

    // STOP clears hold
    bus_start();
    wr_byte(8'hD0, ack);
    wr_byte(8'h02, ack);
    exp_ptr = 2;
    waitc(4);
    check(hold_o == 1'b1, "R11 hold before stop", int'(hold_o), 1);
    bus_stop();
    waitc(10);
    check(hold_o == 1'b0, "R11 hold after stop", int'(hold_o), 0);

    // START in the middle of a byte
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    wr_byte(8'hD0, ack); check(ack, "R10 restart then address ack", int'(ack), 1);
    wr_byte(8'h09, ack);
    exp_ptr = 9;
    wr_byte(8'h5A, ack); check(ack, "R10 write after restart", int'(ack), 1);
    exp_mem[9] = 8'h5A;
    exp_ptr = 10;
    bus_stop();

    // foreign address
    bus_start();
    wr_byte(8'hA0, ack); check(!ack, "R3 foreign address not acked", int'(ack), 0);
    wr_byte(8'h33, ack); check(!ack, "R3 following byte not acked", int'(ack), 0);
    bus_stop();
    waitc(4);
    check(reg_ptr_o == 4'(exp_ptr), "R3 pointer untouched", int'(reg_ptr_o), exp_ptr);

    for (int i = 0; i < 16; i++)
      check(regs[i] == exp_mem[i], "R4 register contents", int'(regs[i]), int'(exp_mem[i]));
    check(contention == 0, "R2 no drive during controller bits", contention, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule